// File: doc/BRIEF.md
# Stepped Frequency Scan Sequencer

This block runs the swept-frequency test mode of a signal source. It keeps track of the operating mode, which the user moves through with a single button. When the scan mode is reached, the same button pressed together with the tuning-step button steps through a short setup. The first gesture takes the current tuning value as the lower edge of the sweep. The second takes it as the upper edge. The third selects a point count from a fixed menu.

From these three values the block works out the increment with a sequential integer divider. It then emits a stream of discrete frequencies in kHz, one per dwell period, from the lower edge up to the upper edge. The final point of every sweep lands exactly on the upper edge, and the stream then starts again at the lower edge.

Both button inputs are single-cycle pulses that have already been debounced. A clock enable paces the dwell counter. Downstream logic turns each announced frequency into a synthesizer tuning word.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, `mode_code` cycles through 0 (CW), 1 (AM), 2 (narrow FM), 3 (wide FM), 4 (broadcast FM), 5 (SCAN) and back to 0. Each step is one cycle in which `mode_pulse` is high and `step_pulse` is low.
- R2: A scan gesture is a cycle in which `mode_pulse` and `step_pulse` are both high. It is acted on only in mode 5 and only in setup states 0 to 2. A gesture in any other mode or state, or a `step_pulse` on its own, changes neither `mode_code` nor `setup_state`.
- R3: Entering mode 5 sets `setup_state` to 0 (capture start). Successive gestures then move it as follows:
  - the first stores `tune_khz` as the start and moves to 1;
  - the second stores `tune_khz` as the stop and moves to 2;
  - the third moves to 3 (calculating), after which the block goes to 4 (running) on its own.
- R4: `steps_idx` values 0 to 5 select 10, 20, 50, 100, 200 or 500 steps. Values 6 and 7 select 500.
- R5: With N steps, step = floor((stop − start)/N). A sweep emits start + k·step for k = 0 … N−1, then exactly stop, then begins again at start.
- R6: If stop is not greater than start, the third gesture leaves `setup_state` at 2 and no scan output is produced.
- R7: Each point is held for `dwell_len` cycles of `tick`, with 0 treated as 1. While `tick` is low the frequency does not advance.
- R8: `freq_valid` pulses for one cycle on the first cycle of each point, only while `scan_active` is high. `scan_active` is high exactly in setup state 4. When the block is not running, `freq_khz` reads 0.
- R9: A `mode_pulse` on its own while in mode 5, in any setup state including running, returns to mode 0 and drops `scan_active`.
- R10: Reset gives mode 0, setup state 0, `scan_active` 0, `freq_valid` 0 and `freq_khz` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable that paces the dwell |
| mode_pulse | input | 1 | Debounced mode button pulse |
| step_pulse | input | 1 | Debounced tuning-step button pulse |
| tune_khz | input | FREQ_W | Current tuning value in kHz |
| steps_idx | input | 3 | Index into the step-count menu |
| dwell_len | input | DWELL_W | Ticks per point (0 acts as 1) |
| freq_khz | output | FREQ_W | Current scan frequency in kHz |
| freq_valid | output | 1 | New-point strobe |
| mode_code | output | 3 | Operating mode |
| setup_state | output | 3 | Scan setup state |
| scan_active | output | 1 | Sweep is running |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Last point of a sweep whose span does not divide evenly.** A design that keeps adding the step would stop short of the upper edge.
- **Span smaller than the step count, so the step is zero.** This must still give N repeats of the start and then the stop. Faulty sequencing shows up as a wrong point count or a wrong final value.
- **Wrap back to the start.** A wrong wrap shows up as a point beyond the stop.
- **Dwell values of 0 and 1.** An off-by-one dwell counter gives the wrong spacing between strobes.
- **Stop at or below start.** A design without the guard would start a sweep.
- **Gestures outside their valid states, and a mode abort in mid-sweep.** A faulty design would corrupt the setup or keep running.

// File: rtl/scan_pkg.sv
package scan_pkg;
   localparam int STEP_CNT_W = 10;

   typedef enum logic [2:0] {
      MD_CW   = 3'd0,
      MD_AM   = 3'd1,
      MD_NBFM = 3'd2,
      MD_WBFM = 3'd3,
      MD_BCFM = 3'd4,
      MD_SCAN = 3'd5
   } mode_e;

   typedef enum logic [2:0] {
      SU_START = 3'd0,
      SU_END   = 3'd1,
      SU_STEPS = 3'd2,
      SU_CALC  = 3'd3,
      SU_RUN   = 3'd4
   } setup_e;

   function automatic logic [STEP_CNT_W-1:0] step_count(input logic [2:0] idx);
      case (idx)
         3'd0:    step_count = STEP_CNT_W'(10);
         3'd1:    step_count = STEP_CNT_W'(20);
         3'd2:    step_count = STEP_CNT_W'(50);
         3'd3:    step_count = STEP_CNT_W'(100);
         3'd4:    step_count = STEP_CNT_W'(200);
         default: step_count = STEP_CNT_W'(500);
      endcase
   endfunction
endpackage

// File: rtl/scan_divider.sv
module scan_divider #(
   parameter int NUM_W = 18,
   parameter int DEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [NUM_W-1:0] quo,
   output logic             done
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [NUM_W-1:0] q_q;
   logic [DEN_W-1:0] r_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic [DEN_W:0]   trial;
   logic [DEN_W:0]   diff;
   logic             fits;

   assign trial = {r_q, q_q[NUM_W-1]};
   assign fits  = trial >= {1'b0, den_q};
   assign diff  = trial - {1'b0, den_q};
   assign quo   = q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_q    <= '0;
         r_q    <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            q_q    <= num;
            r_q    <= '0;
            den_q  <= den;
            cnt_q  <= CNT_W'(NUM_W);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            r_q   <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            q_q   <= {q_q[NUM_W-2:0], fits};
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> den != '0); // R4
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy_q); // R5
endmodule

// File: rtl/scan_menu.sv
module scan_menu
   import scan_pkg::*;
#(
   parameter int FREQ_W = 18
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mode_pulse,
   input  logic                  step_pulse,
   input  logic [FREQ_W-1:0]     tune_khz,
   input  logic [2:0]            steps_idx,
   input  logic                  div_done,
   output mode_e                 mode_q,
   output setup_e                setup_q,
   output logic [FREQ_W-1:0]     start_q,
   output logic [FREQ_W-1:0]     stop_q,
   output logic [STEP_CNT_W-1:0] count_q,
   output logic [STEP_CNT_W-1:0] count_next,
   output logic                  div_go,
   output logic                  run_load
);
   logic gesture, mode_only, in_scan;

   assign gesture    = mode_pulse & step_pulse;
   assign mode_only  = mode_pulse & ~step_pulse;
   assign in_scan    = (mode_q == MD_SCAN);
   assign count_next = step_count(steps_idx);
   assign div_go     = gesture & in_scan & (setup_q == SU_STEPS) & (stop_q > start_q);
   assign run_load   = ~mode_only & (setup_q == SU_CALC) & div_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MD_CW;
         setup_q <= SU_START;
         start_q <= '0;
         stop_q  <= '0;
         count_q <= STEP_CNT_W'(10);
      end else if (mode_only) begin
         setup_q <= SU_START;
         mode_q  <= in_scan ? MD_CW : mode_e'(mode_q + 3'd1);
      end else if (run_load) begin
         setup_q <= SU_RUN;
      end else if (gesture && in_scan) begin
         case (setup_q)
            SU_START: begin
               start_q <= tune_khz;
               setup_q <= SU_END;
            end
            SU_END: begin
               stop_q  <= tune_khz;
               setup_q <= SU_STEPS;
            end
            SU_STEPS: begin
               count_q <= count_next;
               if (div_go) setup_q <= SU_CALC;
            end
            default: ;
         endcase
      end
   end

   AST_SETUP_ONLY_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      setup_q != SU_START |-> mode_q == MD_SCAN); // R3
   AST_RUN_NEEDS_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      setup_q == SU_RUN |-> stop_q > start_q); // R6
   AST_ABORT_TO_CW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_only && in_scan) |=> (mode_q == MD_CW && setup_q == SU_START)); // R9
   AST_STEP_ALONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_pulse && setup_q != SU_CALC) |=> ($stable(mode_q) && $stable(setup_q))); // R2
endmodule

// File: rtl/scan_stepper.sv
module scan_stepper #(
   parameter int FREQ_W  = 18,
   parameter int DWELL_W = 16,
   parameter int CNT_W   = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               run,
   input  logic               tick,
   input  logic [FREQ_W-1:0]  start,
   input  logic [FREQ_W-1:0]  stop,
   input  logic [FREQ_W-1:0]  step,
   input  logic [CNT_W-1:0]   count,
   input  logic [DWELL_W-1:0] dwell_len,
   output logic [FREQ_W-1:0]  freq_q,
   output logic               valid_q
);
   logic [CNT_W-1:0]   k_q;
   logic [DWELL_W-1:0] dw_q;
   logic [DWELL_W-1:0] dwell_last;

   assign dwell_last = (dwell_len == '0) ? '0 : dwell_len - DWELL_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_q  <= '0;
         k_q     <= '0;
         dw_q    <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (load) begin
            freq_q  <= start;
            k_q     <= '0;
            dw_q    <= '0;
            valid_q <= 1'b1;
         end else if (run && tick) begin
            if (dw_q >= dwell_last) begin
               dw_q    <= '0;
               valid_q <= 1'b1;
               if (k_q == count) begin
                  freq_q <= start;
                  k_q    <= '0;
               end else begin
                  freq_q <= (k_q == count - CNT_W'(1)) ? stop : freq_q + step;
                  k_q    <= k_q + CNT_W'(1);
               end
            end else begin
               dw_q <= dw_q + DWELL_W'(1);
            end
         end
      end
   end

   AST_FREQ_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (freq_q >= start && freq_q <= stop)); // R5
   AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (run && k_q == count) |-> freq_q == stop); // R5
   AST_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick && !load) |=> $stable(freq_q)); // R7
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
   import scan_pkg::*;
#(
   parameter int FREQ_W      = 18,
   parameter int DWELL_W     = 16,
   parameter bit HOLD_OUTPUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               mode_pulse,
   input  logic               step_pulse,
   input  logic [FREQ_W-1:0]  tune_khz,
   input  logic [2:0]         steps_idx,
   input  logic [DWELL_W-1:0] dwell_len,
   output logic [FREQ_W-1:0]  freq_khz,
   output logic               freq_valid,
   output logic [2:0]         mode_code,
   output logic [2:0]         setup_state,
   output logic               scan_active
);
   initial begin
      assert (FREQ_W > STEP_CNT_W) else $error("FREQ_W must exceed the step counter width");
      assert (DWELL_W >= 1) else $error("DWELL_W must be at least 1");
   end

   mode_e                 mode_q;
   setup_e                setup_q;
   logic [FREQ_W-1:0]     start_q, stop_q, step_w, freq_raw;
   logic [STEP_CNT_W-1:0] count_q, count_next;
   logic                  div_go, div_done, run_load, valid_raw;

   scan_menu #(.FREQ_W(FREQ_W)) menu_i (
      .clk(clk), .rst_n(rst_n), .mode_pulse(mode_pulse), .step_pulse(step_pulse),
      .tune_khz(tune_khz), .steps_idx(steps_idx), .div_done(div_done),
      .mode_q(mode_q), .setup_q(setup_q), .start_q(start_q), .stop_q(stop_q),
      .count_q(count_q), .count_next(count_next), .div_go(div_go), .run_load(run_load)
   );

   scan_divider #(.NUM_W(FREQ_W), .DEN_W(STEP_CNT_W)) div_i (
      .clk(clk), .rst_n(rst_n), .go(div_go), .num(stop_q - start_q),
      .den(count_next), .quo(step_w), .done(div_done)
   );

   scan_stepper #(.FREQ_W(FREQ_W), .DWELL_W(DWELL_W), .CNT_W(STEP_CNT_W)) step_i (
      .clk(clk), .rst_n(rst_n), .load(run_load), .run(scan_active), .tick(tick),
      .start(start_q), .stop(stop_q), .step(step_w), .count(count_q),
      .dwell_len(dwell_len), .freq_q(freq_raw), .valid_q(valid_raw)
   );

   assign scan_active = (setup_q == SU_RUN);
   assign freq_valid  = valid_raw & scan_active;
   assign mode_code   = mode_q;
   assign setup_state = setup_q;

   generate
      if (HOLD_OUTPUT) begin : g_hold
         assign freq_khz = freq_raw;
      end else begin : g_gate
         assign freq_khz = scan_active ? freq_raw : '0;
      end
   endgenerate

   AST_VALID_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      freq_valid |-> mode_code == 3'd5); // R8
endmodule

// File: tb/scan_sequencer_tb_top.sv
module scan_sequencer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int FREQ_W     = 18;
   localparam int DWELL_W    = 16;
   localparam int WD_CYCLES  = 150000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               tick = 1'b1;
   logic               mode_pulse = 1'b0;
   logic               step_pulse = 1'b0;
   logic [FREQ_W-1:0]  tune_khz = '0;
   logic [2:0]         steps_idx = '0;
   logic [DWELL_W-1:0] dwell_len = DWELL_W'(1);
   logic [FREQ_W-1:0]  freq_khz;
   logic               freq_valid;
   logic [2:0]         mode_code;
   logic [2:0]         setup_state;
   logic               scan_active;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scan_sequencer #(.FREQ_W(FREQ_W), .DWELL_W(DWELL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode_pulse(mode_pulse),
      .step_pulse(step_pulse), .tune_khz(tune_khz), .steps_idx(steps_idx),
      .dwell_len(dwell_len), .freq_khz(freq_khz), .freq_valid(freq_valid),
      .mode_code(mode_code), .setup_state(setup_state), .scan_active(scan_active)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic press(input bit m, input bit s);
      @(negedge clk);
      mode_pulse = m;
      step_pulse = s;
      @(negedge clk);
      mode_pulse = 1'b0;
      step_pulse = 1'b0;
   endtask

   task automatic goto_cw();
      for (int i = 0; i < 8 && mode_code != 3'd0; i++) press(1'b1, 1'b0);
   endtask

   task automatic run_setup(input int start, input int stop, input int idx, input int third);
      goto_cw();
      for (int i = 0; i < 5; i++) press(1'b1, 1'b0);
      chk("R3 scan entry setup", setup_state, 0);
      tune_khz = FREQ_W'(start);
      press(1'b1, 1'b1);
      chk("R3 after start capture", setup_state, 1);
      tune_khz = FREQ_W'(stop);
      press(1'b1, 1'b1);
      chk("R3 after stop capture", setup_state, 2);
      steps_idx = 3'(idx);
      press(1'b1, 1'b1);
      chk("R3/R6 after steps gesture", setup_state, third);
   endtask

   task automatic check_sweep(input int start, input int stop, input int n,
                              input int dwell, input int npoints);
      int step = (stop - start) / n;
      int deff = (dwell == 0) ? 1 : dwell;
      int w = 0;
      int bad_v = 0, bad_g = 0;
      while (!freq_valid && w < 200) begin
         @(negedge clk);
         w++;
      end
      chk("R5 first point value", freq_khz, start);
      chk("R8 active during run", scan_active, 1);
      for (int p = 1; p < npoints; p++) begin
         int gap = 0;
         int kk = p % (n + 1);
         int exp = (kk == n) ? stop : start + kk * step;
         do begin
            @(negedge clk);
            gap++;
         end while (!freq_valid && gap < deff + 5);
         if (freq_khz != FREQ_W'(exp) && bad_v == 0) begin
            bad_v++;
            chk("R5 sweep point", freq_khz, exp);
         end
         if (gap != deff && bad_g == 0) begin
            bad_g++;
            chk("R7 dwell spacing", gap, deff);
         end
      end
      if (bad_v == 0) chk("R5 sweep points all matched", 1, 1);
      if (bad_g == 0) chk("R7/R8 strobe spacing all matched", 1, 1);
   endtask

   task automatic t_reset();
      chk("R10 reset mode", mode_code, 0);
      chk("R10 reset setup", setup_state, 0);
      chk("R10 reset active", scan_active, 0);
      chk("R10 reset valid", freq_valid, 0);
      chk("R10 reset freq", freq_khz, 0);
   endtask

   task automatic t_mode_cycle();
      for (int i = 1; i <= 6; i++) begin
         press(1'b1, 1'b0);
         chk("R1 mode advance", mode_code, i % 6);
      end
      press(1'b0, 1'b1);
      chk("R2 step alone keeps mode", mode_code, 0);
      press(1'b1, 1'b0);
      press(1'b1, 1'b1);
      chk("R2 gesture outside scan keeps mode", mode_code, 1);
      chk("R2 gesture outside scan keeps setup", setup_state, 0);
      goto_cw();
   endtask

   task automatic t_basic();
      int vcount = 0;
      logic [FREQ_W-1:0] held;
      dwell_len = DWELL_W'(3);
      run_setup(1000, 2000, 0, 3);
      check_sweep(1000, 2000, 10, 3, 23);
      press(1'b1, 1'b1);
      chk("R2 gesture during run ignored", setup_state, 4);
      @(negedge clk);
      tick = 1'b0;
      held = freq_khz;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (freq_valid) vcount++;
      end
      chk("R7 no strobe with tick low", vcount, 0);
      chk("R7 frequency frozen with tick low", freq_khz, held);
      tick = 1'b1;
      press(1'b1, 1'b0);
      chk("R9 abort to CW", mode_code, 0);
      chk("R9 abort drops active", scan_active, 0);
      chk("R8 freq reads zero when idle", freq_khz, 0);
   endtask

   task automatic t_sweeps();
      dwell_len = '0;
      run_setup(100, 1234, 2, 3);
      check_sweep(100, 1234, 50, 0, 53);
      goto_cw();
      dwell_len = DWELL_W'(2);
      run_setup(455, 470, 1, 3);
      check_sweep(455, 470, 20, 2, 22);
      goto_cw();
      dwell_len = DWELL_W'(1);
      run_setup(0, 150000, 7, 3);
      check_sweep(0, 150000, 500, 1, 502);
      goto_cw();
      run_setup(5000, 5200, 3, 3);
      check_sweep(5000, 5200, 100, 1, 102);
      goto_cw();
      run_setup(1000, 1400, 4, 3);
      check_sweep(1000, 1400, 200, 1, 202);
      goto_cw();
      run_setup(7000, 9000, 5, 3);
      check_sweep(7000, 9000, 500, 1, 502);
      goto_cw();
   endtask

   task automatic t_refuse();
      int vcount = 0;
      run_setup(2000, 1000, 0, 2);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (freq_valid) vcount++;
      end
      chk("R6 reversed span stays in steps", setup_state, 2);
      chk("R6 reversed span no strobes", vcount, 0);
      chk("R6 reversed span inactive", scan_active, 0);
      run_setup(500, 500, 1, 2);
      press(1'b1, 1'b1);
      repeat (30) @(negedge clk);
      chk("R6 equal span still refused", setup_state, 2);
      press(1'b1, 1'b0);
      chk("R9 abort from setup", mode_code, 0);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode_cycle();
      t_basic();
      t_sweeps();
      t_refuse();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule